// File: doc/BRIEF.md
# Program-Counter Trace Event Generator

This block sits beside a processor and watches the instructions it retires. Each retired instruction's program counter is compared against a small bank of trigger addresses. On a hit, the block captures a complete, self-describing event in that same retirement cycle. The event holds an event-type code, the value of a free-running cycle counter, and an optional payload. The payload can contain two snooped general-purpose registers and one word read from the stack at a configured word offset above the stack pointer.

The captured event is held in a single buffer and sent as 32-bit words on a valid/ready stream, with a flag on the final word. The processor is never stalled. A trigger that fires while the buffer is still occupied is dropped, and a saturating overflow counter records it. Trigger addresses, enables, type codes, payload selection, register selects and the stack offset are written through a simple write-only configuration port.

Top module: `pc_event_gen`

## Requirements
- R1: After reset, `outValid`, `outLast` and `ovfCount` are 0, `regSelA` and `regSelB` are 0, and every trigger is disabled, so retiring any PC produces no event.
- R2: Trigger i fires only in a cycle where `retire` is 1, its enable bit is set, and `pc` equals its configured address. If any of the three is missing, no event is produced.
- R3: When several triggers fire in one cycle, only the one with the lowest index produces an event.
- R4: An event is 2 to 5 words. Word 0 is the header: bits 31:24 hold the type code, bits 23:16 the trigger index, bits 15:8 the total word count, and bits 7:0 are zero. Word 1 is the timestamp. The selected payload words follow in the fixed order register A, register B, stack word. `outLast` is 1 on the final word only, and `outValid` falls after that word is accepted.
- R5: The timestamp is a 32-bit counter. It is 0 in the first cycle after reset, increments every clock, and is captured in the trigger cycle rather than the send cycle.
- R6: Payload values are the ones present in the trigger cycle. Register A is `regDataA`, register B is `regDataB`, and the stack word is `stackData`, where `stackAddr` = `sp` + 4 × offset.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outLast` hold their values.
- R8: The buffer is occupied from the capture until the handshake of the final word, that cycle included. A trigger that fires while the buffer is occupied produces no event and increments `ovfCount`, which saturates at its all-ones value.
- R9: Configuration writes use `cfgWe` with `cfgAddr`. Address 2i sets trigger i's address. Address 2i+1 sets trigger i's control: bit 0 is enable; bit 1 selects register A, bit 2 register B and bit 3 the stack word; bits 15:8 hold the type code. Address 2×NUM_TRIG sets `regSelA` from bits 4:0, `regSelB` from bits 12:8, and the stack word offset from bits 23:16.
- R10: `regSelA` and `regSelB` continuously show the configured register indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration register address |
| cfgWdata | input | 32 | Configuration write data |
| retire | input | 1 | An instruction retires this cycle |
| pc | input | 32 | PC of the retiring instruction |
| regSelA | output | REG_IDX_W | Register index snooped as payload A |
| regSelB | output | REG_IDX_W | Register index snooped as payload B |
| regDataA | input | 32 | Value of register `regSelA` |
| regDataB | input | 32 | Value of register `regSelB` |
| sp | input | 32 | Current stack pointer |
| stackAddr | output | 32 | Stack word address to read |
| stackData | input | 32 | Stack word at `stackAddr` |
| outValid | output | 1 | Event word valid |
| outReady | input | 1 | Sink accepts the word |
| outData | output | 32 | Event word |
| outLast | output | 1 | Final word of the event |
| ovfCount | output | OVF_W | Saturating count of dropped events |

## Verification
A wrong word-sequencer state shows up at the very next accepted word. It appears as a misplaced or missing payload word, a header count that disagrees with the number of words delivered, or `outLast` on the wrong word. A stuck occupancy flag shows within one event: either `outValid` never falls, or a later trigger is counted as an overflow instead of producing a packet. A wrong timestamp or payload latch is exposed by the first packet's contents, because the bench changes register values and the counter right after the trigger cycle.

// File: rtl/evgen_pkg.sv
package evgen_pkg;
  localparam int WORD_W = 32;
  localparam int TYPE_W = 8;
  localparam int MASK_W = 3;

  typedef enum logic [2:0] {SEL_HDR, SEL_TS, SEL_A, SEL_B, SEL_S} wordSel_t;

  typedef struct packed {
    logic     capture;
    wordSel_t sel;
  } evStrobe_t;
endpackage

// File: rtl/evgen_cfg.sv
module evgen_cfg
  import evgen_pkg::*;
#(
  parameter int NUM_TRIG  = 4,
  parameter int CFG_AW    = 4,
  parameter int REG_IDX_W = 5,
  parameter int OFF_W     = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cfgWe,
  input  logic [CFG_AW-1:0]                  cfgAddr,
  input  logic [WORD_W-1:0]                  cfgWdata,
  output logic [NUM_TRIG-1:0][WORD_W-1:0]    trigAddr,
  output logic [NUM_TRIG-1:0]                trigEn,
  output logic [NUM_TRIG-1:0][MASK_W-1:0]    trigMask,
  output logic [NUM_TRIG-1:0][TYPE_W-1:0]    trigType,
  output logic [REG_IDX_W-1:0]               selA,
  output logic [REG_IDX_W-1:0]               selB,
  output logic [OFF_W-1:0]                   stackOff
);
  localparam int GLOBAL_ADDR = 2 * NUM_TRIG;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    always_ff @(posedge clk) begin
      if (!rstN) begin
        trigAddr[i] <= '0;
        trigEn[i]   <= 1'b0;
        trigMask[i] <= '0;
        trigType[i] <= '0;
      end else if (cfgWe) begin
        if (cfgAddr == CFG_AW'(2 * i)) begin
          trigAddr[i] <= cfgWdata;
        end
        if (cfgAddr == CFG_AW'(2 * i + 1)) begin
          trigEn[i]   <= cfgWdata[0];
          trigMask[i] <= cfgWdata[MASK_W:1];
          trigType[i] <= cfgWdata[8 +: TYPE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selA     <= '0;
      selB     <= '0;
      stackOff <= '0;
    end else if (cfgWe && cfgAddr == CFG_AW'(GLOBAL_ADDR)) begin
      selA     <= cfgWdata[REG_IDX_W-1:0];
      selB     <= cfgWdata[8 +: REG_IDX_W];
      stackOff <= cfgWdata[16 +: OFF_W];
    end
  end
endmodule

// File: rtl/evgen_ctrl.sv
module evgen_ctrl
  import evgen_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int OVF_W    = 16,
  parameter int IDX_W    = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            retire,
  input  logic [WORD_W-1:0]               pc,
  input  logic [NUM_TRIG-1:0][WORD_W-1:0] trigAddr,
  input  logic [NUM_TRIG-1:0]             trigEn,
  input  logic [MASK_W-1:0]               capMask,
  input  logic                            outReady,
  output evStrobe_t                       strobe,
  output logic [IDX_W-1:0]                winIdx,
  output logic                            outValid,
  output logic                            outLast,
  output logic [OVF_W-1:0]                ovfCount
);
  logic [NUM_TRIG-1:0] hit;
  logic                anyHit;
  logic                busy;
  wordSel_t            curSel;
  wordSel_t            nxtSel;
  logic                hasNext;
  logic                accept;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_cmp
    assign hit[i] = retire && trigEn[i] && (pc == trigAddr[i]);
  end

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  always_comb begin
    hasNext = 1'b1;
    nxtSel  = SEL_TS;
    case (curSel)
      SEL_HDR: nxtSel = SEL_TS;
      SEL_TS: begin
        if (capMask[0])      nxtSel = SEL_A;
        else if (capMask[1]) nxtSel = SEL_B;
        else if (capMask[2]) nxtSel = SEL_S;
        else                 hasNext = 1'b0;
      end
      SEL_A: begin
        if (capMask[1])      nxtSel = SEL_B;
        else if (capMask[2]) nxtSel = SEL_S;
        else                 hasNext = 1'b0;
      end
      SEL_B: begin
        if (capMask[2]) nxtSel = SEL_S;
        else            hasNext = 1'b0;
      end
      default: hasNext = 1'b0;
    endcase
  end

  assign accept         = busy && outReady;
  assign strobe.capture = anyHit && !busy;
  assign strobe.sel     = curSel;
  assign outValid       = busy;
  assign outLast        = busy && !hasNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      curSel <= SEL_HDR;
    end else if (strobe.capture) begin
      busy   <= 1'b1;
      curSel <= SEL_HDR;
    end else if (accept) begin
      if (hasNext) curSel <= nxtSel;
      else         busy   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfCount <= '0;
    end else if (anyHit && busy && ovfCount != '1) begin
      ovfCount <= ovfCount + 1'b1;
    end
  end

  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rstN)
    busy && !outReady |=> busy && curSel == $past(curSel)); // R7
  AST_OVF_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCount != $past(ovfCount)) |-> $past(busy)); // R8
  AST_OVF_MONO: assert property (@(posedge clk) disable iff (!rstN)
    ovfCount >= $past(ovfCount)); // R8
  AST_START_ON_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(retire)); // R2
endmodule

// File: rtl/evgen_datapath.sv
module evgen_datapath
  import evgen_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int OFF_W    = 8,
  parameter int IDX_W    = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  evStrobe_t                       strobe,
  input  logic [IDX_W-1:0]                winIdx,
  input  logic [NUM_TRIG-1:0][MASK_W-1:0] trigMask,
  input  logic [NUM_TRIG-1:0][TYPE_W-1:0] trigType,
  input  logic [OFF_W-1:0]                stackOff,
  input  logic [WORD_W-1:0]               regDataA,
  input  logic [WORD_W-1:0]               regDataB,
  input  logic [WORD_W-1:0]               sp,
  input  logic [WORD_W-1:0]               stackData,
  output logic [WORD_W-1:0]               stackAddr,
  output logic [MASK_W-1:0]               capMask,
  output logic [WORD_W-1:0]               outData
);
  logic [WORD_W-1:0] tsCnt;
  logic [WORD_W-1:0] capTs, capA, capB, capS;
  logic [TYPE_W-1:0] capType;
  logic [IDX_W-1:0]  capIdx;
  logic [7:0]        nWords;

  assign stackAddr = sp + {{(WORD_W - OFF_W - 2){1'b0}}, stackOff, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTs   <= '0;
      capA    <= '0;
      capB    <= '0;
      capS    <= '0;
      capType <= '0;
      capIdx  <= '0;
      capMask <= '0;
    end else if (strobe.capture) begin
      capTs   <= tsCnt;
      capA    <= regDataA;
      capB    <= regDataB;
      capS    <= stackData;
      capType <= trigType[winIdx];
      capIdx  <= winIdx;
      capMask <= trigMask[winIdx];
    end
  end

  assign nWords = 8'd2 + 8'(capMask[0]) + 8'(capMask[1]) + 8'(capMask[2]);

  always_comb begin
    case (strobe.sel)
      SEL_HDR: outData = {capType, 8'(capIdx), nWords, 8'h00};
      SEL_TS:  outData = capTs;
      SEL_A:   outData = capA;
      SEL_B:   outData = capB;
      default: outData = capS;
    endcase
  end
endmodule

// File: rtl/pc_event_gen.sv
module pc_event_gen
  import evgen_pkg::*;
#(
  parameter int NUM_TRIG  = 4,
  parameter int REG_IDX_W = 5,
  parameter int OFF_W     = 8,
  parameter int OVF_W     = 16,
  parameter int CFG_AW    = $clog2(2 * NUM_TRIG + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [31:0]          cfgWdata,
  input  logic                 retire,
  input  logic [31:0]          pc,
  output logic [REG_IDX_W-1:0] regSelA,
  output logic [REG_IDX_W-1:0] regSelB,
  input  logic [31:0]          regDataA,
  input  logic [31:0]          regDataB,
  input  logic [31:0]          sp,
  output logic [31:0]          stackAddr,
  input  logic [31:0]          stackData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [31:0]          outData,
  output logic                 outLast,
  output logic [OVF_W-1:0]     ovfCount
);
  localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [NUM_TRIG-1:0][WORD_W-1:0] trigAddr;
  logic [NUM_TRIG-1:0]             trigEn;
  logic [NUM_TRIG-1:0][MASK_W-1:0] trigMask;
  logic [NUM_TRIG-1:0][TYPE_W-1:0] trigType;
  logic [OFF_W-1:0]                stackOff;
  logic [MASK_W-1:0]               capMask;
  logic [IDX_W-1:0]                winIdx;
  evStrobe_t                       strobe;

  evgen_cfg #(.NUM_TRIG(NUM_TRIG), .CFG_AW(CFG_AW), .REG_IDX_W(REG_IDX_W), .OFF_W(OFF_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .trigAddr(trigAddr), .trigEn(trigEn), .trigMask(trigMask), .trigType(trigType),
    .selA(regSelA), .selB(regSelB), .stackOff(stackOff)
  );

  evgen_ctrl #(.NUM_TRIG(NUM_TRIG), .OVF_W(OVF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .retire(retire), .pc(pc), .trigAddr(trigAddr), .trigEn(trigEn),
    .capMask(capMask), .outReady(outReady), .strobe(strobe), .winIdx(winIdx),
    .outValid(outValid), .outLast(outLast), .ovfCount(ovfCount)
  );

  evgen_datapath #(.NUM_TRIG(NUM_TRIG), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .winIdx(winIdx), .trigMask(trigMask),
    .trigType(trigType), .stackOff(stackOff), .regDataA(regDataA), .regDataB(regDataB),
    .sp(sp), .stackData(stackData), .stackAddr(stackAddr), .capMask(capMask), .outData(outData)
  );

  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast)); // R7
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R4
endmodule

// File: tb/sim_pc_event_gen.sv
module sim_pc_event_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        retire = 1'b0;
  logic [31:0] pc = '0;
  logic [4:0]  regSelA, regSelB;
  logic [31:0] regDataA, regDataB, stackAddr, stackData;
  logic [31:0] sp = 32'h0000_8000;
  logic        outValid, outLast, outReady = 1'b0;
  logic [31:0] outData;
  logic [15:0] ovfCount;
  logic [31:0] seed = 32'h1234;
  logic [31:0] bcnt;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] ew [5];
  int nExp;
  logic [31:0] fireTs, fireSeed;

  always #5 clk = ~clk;

  assign regDataA  = seed * 32'd7 + 32'(regSelA);
  assign regDataB  = seed * 32'd11 + 32'(regSelB);
  assign stackData = stackAddr ^ seed;

  pc_event_gen u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .retire(retire), .pc(pc), .regSelA(regSelA), .regSelB(regSelB), .regDataA(regDataA),
    .regDataB(regDataB), .sp(sp), .stackAddr(stackAddr), .stackData(stackData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .ovfCount(ovfCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) bcnt <= '0;
    else       bcnt <= bcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic fire(input logic [31:0] p);
    retire = 1'b1; pc = p;
    fireTs = bcnt; fireSeed = seed;
    @(negedge clk);
    retire = 1'b0;
    seed = seed + 32'h101;
  endtask

  function automatic void buildExp(input logic [7:0] typ, input int idx, input logic [2:0] m,
                                   input logic [4:0] sa, input logic [4:0] sb, input logic [7:0] off);
    nExp = 2;
    ew[1] = fireTs;
    if (m[0]) begin ew[nExp] = fireSeed * 32'd7 + 32'(sa); nExp++; end
    if (m[1]) begin ew[nExp] = fireSeed * 32'd11 + 32'(sb); nExp++; end
    if (m[2]) begin ew[nExp] = (sp + 32'(off) * 4) ^ fireSeed; nExp++; end
    ew[0] = {typ, 8'(idx), 8'(nExp), 8'h00};
  endfunction

  task automatic collect(input int stallBase, input string req, input bit hitLast, input logic [31:0] hitPc);
    for (int w = 0; w < nExp; w++) begin
      for (int s = 0; s < (w + stallBase) % 3; s++) begin
        outReady = 1'b0;
        @(negedge clk);
        chk(outValid && outData == ew[w], "R7 stall hold", outData, ew[w]);
      end
      chk(outValid, {req, " valid"}, 32'(outValid), 1);
      chk(outData == ew[w], {req, " word"}, outData, ew[w]);
      chk(outLast == (w == nExp - 1), "R4 last flag", 32'(outLast), 32'(w == nExp - 1));
      outReady = 1'b1;
      if (hitLast && w == nExp - 1) begin retire = 1'b1; pc = hitPc; end
      @(negedge clk);
      outReady = 1'b0; retire = 1'b0;
    end
    chk(!outValid, "R4 valid falls after last", 32'(outValid), 0);
  endtask

  task automatic expectNone(input string req);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk(!outValid, req, 32'(outValid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ovfBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!outValid && !outLast, "R1 out idle", {outValid, outLast}, 0);
    chk(ovfCount == 0, "R1 ovf zero", 32'(ovfCount), 0);
    chk(regSelA == 0 && regSelB == 0, "R1 selects zero", {regSelA, regSelB}, 0);
    fire(32'h0);
    expectNone("R1 triggers disabled");

    // R9 R10 register select outputs
    cfgWrite(4'd8, 32'h0003_0A05);
    chk(regSelA == 5'd5 && regSelB == 5'd10, "R10 selects", {regSelA, regSelB}, {5'd5, 5'd10});
    chk(stackAddr == sp + 12, "R6 stack addr", stackAddr, sp + 12);

    // R2 R4 R5 R6 R9 sweep over trigger index and payload mask
    for (int i = 0; i < 4; i++) begin
      for (int t = 0; t < 4; t++) begin
        cfgWrite(4'(2 * t), 32'h1000 + 32'(t) * 32'h40);
        cfgWrite(4'(2 * t + 1), 32'h1 | (32'(8'h20 + 8'(t)) << 8));
      end
      for (int m = 0; m < 8; m++) begin
        logic [4:0] sa, sb;
        logic [7:0] off;
        sa = 5'((i * 5 + m) % 32); sb = 5'((i * 3 + m + 1) % 32); off = 8'(i + m);
        cfgWrite(4'(2 * i + 1), 32'h1 | (32'(m) << 1) | (32'(8'h40 + 8'(i * 8 + m)) << 8));
        cfgWrite(4'd8, {8'h0, off, 3'b0, sb, 3'b0, sa});
        sp = 32'h8000 + 32'(i * 64 + m * 4);
        @(negedge clk);
        fire(32'h1000 + 32'(i) * 32'h40);
        buildExp(8'h40 + 8'(i * 8 + m), i, 3'(m), sa, sb, off);
        collect(m + i, "R4 R5 R6 packet", 1'b0, 32'h0);
      end
    end

    // R2 non-matching conditions
    fire(32'h1004);
    expectNone("R2 pc mismatch");
    retire = 1'b0; pc = 32'h1000;
    expectNone("R2 retire low");
    cfgWrite(4'd1, 32'h0);
    fire(32'h1000);
    expectNone("R2 trigger disabled");

    // R3 priority sweep
    for (int t = 0; t < 4; t++) cfgWrite(4'(2 * t), 32'h200);
    for (int s = 0; s < 16; s++) begin
      int low;
      low = -1;
      for (int t = 3; t >= 0; t--) if (s[t]) low = t;
      for (int t = 0; t < 4; t++) cfgWrite(4'(2 * t + 1), 32'(s[t]) | (32'(8'h10 + 8'(t)) << 8));
      fire(32'h200);
      if (low < 0) expectNone("R3 none enabled");
      else begin
        buildExp(8'h10 + 8'(low), low, 3'b000, 5'd0, 5'd0, 8'd0);
        collect(s, "R3 priority", 1'b0, 32'h0);
      end
    end

    // R8 overflow during stall, then drop on last-word handshake cycle
    cfgWrite(4'd1, 32'h0000_3303);
    ovfBefore = ovfCount;
    fire(32'h200);
    buildExp(8'h33, 0, 3'b001, regSelA, regSelB, 8'd0);
    for (int k = 0; k < 5; k++) begin retire = 1'b1; pc = 32'h200; @(negedge clk); end
    retire = 1'b0;
    chk(ovfCount == ovfBefore + 5, "R8 overflow count", 32'(ovfCount), 32'(ovfBefore + 5));
    collect(0, "R8 buffered packet", 1'b1, 32'h200);
    chk(ovfCount == ovfBefore + 6, "R8 last-cycle drop", 32'(ovfCount), 32'(ovfBefore + 6));

    // R8 saturation
    fire(32'h200);
    buildExp(8'h33, 0, 3'b001, regSelA, regSelB, 8'd0);
    retire = 1'b1; pc = 32'h200;
    repeat (66000) @(negedge clk);
    retire = 1'b0;
    chk(ovfCount == 16'hFFFF, "R8 saturate", 32'(ovfCount), 32'hFFFF);
    collect(1, "R8 packet after saturate", 1'b0, 32'h0);
    chk(ovfCount == 16'hFFFF, "R8 stays saturated", 32'(ovfCount), 32'hFFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule